// File: doc/BRIEF.md
# Power Mode and Reset Sequencer

This block is the clock and reset controller for an 8-bit microcontroller core. It runs on the raw oscillator. It halves the oscillator into a state strobe, and it groups six strobes into one machine-cycle strobe, so one machine cycle spans 12 oscillator periods. Downstream logic uses two clock-enable strobes instead of gated clocks. The CPU enable drives the instruction datapath. The peripheral enable drives the timers, the serial port and the interrupt logic.

The external reset pin is qualified by counting state strobes while the pin is high. The core reset asserts only after two full machine cycles. The port preset output, which forces all port latches to ones, follows the pin at once. Software enters a low-power mode with one-cycle request pulses from the power-control register. Idle stops only the CPU enable. Power-down freezes the divider and both enables. An enabled interrupt ends idle. Only the reset pin ends power-down. If reset ends idle, the CPU runs until qualification completes, and during that window RAM writes are inhibited.

States:
- `PM_RESET`: the core reset is held.
- `PM_RUN`: normal operation.
- `PM_IDLE`: the CPU enable is stopped.
- `PM_IDLE_RSTX`: idle has been left by the reset pin and the CPU runs with RAM locked.
- `PM_PDOWN`: the divider and both enables are frozen.
- `PM_PD_RESTART`: the pin is high after power-down and the divider is running again.

Transitions:
- Qualification complete goes from any state except `PM_PDOWN` to `PM_RESET`.
- Pin low goes from `PM_RESET` to `PM_RUN`.
- A power-down request goes from `PM_RUN` to `PM_PDOWN`. It wins over an idle request in the same cycle.
- An idle request goes from `PM_RUN` to `PM_IDLE`.
- Wake goes from `PM_IDLE` to `PM_RUN`.
- Pin high goes from `PM_IDLE` to `PM_IDLE_RSTX`.
- Pin low goes from `PM_IDLE_RSTX` to `PM_RUN`.
- Pin high goes from `PM_PDOWN` to `PM_PD_RESTART`.
- Pin low goes from `PM_PD_RESTART` back to `PM_PDOWN`.

Top module: `pm_rst_seq`

## Requirements
- R1: Outside power-down, the state strobe fires on every second oscillator cycle and never in two cycles in a row. `periph_clk_en` is high on exactly the strobe cycles in `PM_RUN`.
- R2: `mc_tick` pulses once every 12 oscillator cycles: on every sixth state strobe.
- R3: `sfr_rst` rises only after `rst_pin` has been high for 12 consecutive state strobes. A shorter pulse leaves `sfr_rst` low.
- R4: `port_preset` is high in the same cycle that `rst_pin` is high, and it stays high while `sfr_rst` is high.
- R5: After an `idle_set` pulse, `cpu_clk_en` stays low and `periph_clk_en` keeps pulsing. A `wake_irq` pulse returns the block to normal running.
- R6: If `rst_pin` rises during idle, `cpu_clk_en` resumes pulsing with `ram_wr_inhibit` high until `sfr_rst` asserts.
- R7: After a `pd_set` pulse, both enables and `mc_tick` stay low, and `wake_irq` has no effect.
- R8: Power-down ends only through the reset pin. Qualification starts from zero when the pin rises, and a pulse shorter than 12 strobes returns the block to power-down.
- R9: When `idle_set` and `pd_set` arrive in the same cycle, power-down is entered.
- R10: A request applies once: after idle is left, the CPU enable keeps pulsing without a new request.
- R11: `sfr_rst` is high from power-on reset. It falls in the first cycle after `rst_pin` is low, and the block then runs normally with `ram_wr_inhibit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, synchronous to clk |
| idle_set | input | 1 | One-cycle idle request pulse |
| pd_set | input | 1 | One-cycle power-down request pulse |
| wake_irq | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock-enable strobe |
| periph_clk_en | output | 1 | Peripheral clock-enable strobe |
| mc_tick | output | 1 | Machine-cycle strobe |
| sfr_rst | output | 1 | Synchronous core register reset |
| port_preset | output | 1 | Forces port latches to ones |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |

## Verification
The embedded properties check the following on every clock:
- Strobes never land in consecutive cycles.
- The qualification count never passes its limit.
- Power-down holds both enables low and is left only with the pin high.
- Idle is left only through the pin, a wake or qualification.
- The core reset never rises without the pin.

The bench's scenarios are needed to show the exact cycle counts: 12 strobes before reset, 12 oscillator cycles per machine cycle, the CPU running with RAM locked after reset ends idle, and qualification restarting after power-down.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
    typedef enum logic [2:0] {
        PM_RESET      = 3'd0,
        PM_RUN        = 3'd1,
        PM_IDLE       = 3'd2,
        PM_IDLE_RSTX  = 3'd3,
        PM_PDOWN      = 3'd4,
        PM_PD_RESTART = 3'd5
    } pm_state_e;
endpackage

// File: rtl/pm_clk_div.sv
module pm_clk_div #(
    parameter int STATES_PER_MC = 6
) (
    input  logic clk,
    input  logic arst_n,
    input  logic freeze,
    output logic tick,
    output logic mc_tick
);
    localparam int PW = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
    localparam logic [PW-1:0] LAST = PW'(STATES_PER_MC - 1);

    logic          half_q;
    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            half_q <= 1'b0;
        end else if (freeze) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    assign tick = half_q & ~freeze;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign mc_tick = tick & (phase_q == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!arst_n)
        tick |=> !tick); // R1
    AST_MC_ON_TICK: assert property (@(posedge clk) disable iff (!arst_n)
        mc_tick |=> !mc_tick); // R2
endmodule

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
    parameter int QUAL_TICKS = 12
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin,
    input  logic clear,
    input  logic tick,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (!rst_pin || clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qualified = (cnt_q == LIMIT);

    AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LIMIT); // R3
    AST_QUAL_NEEDS_PIN: assert property (@(posedge clk) disable iff (!arst_n)
        qualified |-> $past(rst_pin)); // R3
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_seq_pkg::*;
(
    input  logic      clk,
    input  logic      arst_n,
    input  logic      rst_pin,
    input  logic      qualified,
    input  logic      idle_set,
    input  logic      pd_set,
    input  logic      wake_irq,
    input  logic      tick,
    output pm_state_e state,
    output logic      freeze,
    output logic      cpu_clk_en,
    output logic      periph_clk_en,
    output logic      sfr_rst,
    output logic      ram_wr_inhibit
);
    pm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= PM_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RESET: begin
                if (!rst_pin) state_d = PM_RUN;
            end
            PM_RUN: begin
                if (qualified)     state_d = PM_RESET;
                else if (pd_set)   state_d = PM_PDOWN;
                else if (idle_set) state_d = PM_IDLE;
            end
            PM_IDLE: begin
                if (qualified)     state_d = PM_RESET;
                else if (rst_pin)  state_d = PM_IDLE_RSTX;
                else if (wake_irq) state_d = PM_RUN;
            end
            PM_IDLE_RSTX: begin
                if (qualified)     state_d = PM_RESET;
                else if (!rst_pin) state_d = PM_RUN;
            end
            PM_PDOWN: begin
                if (rst_pin) state_d = PM_PD_RESTART;
            end
            PM_PD_RESTART: begin
                if (qualified)     state_d = PM_RESET;
                else if (!rst_pin) state_d = PM_PDOWN;
            end
            default: state_d = PM_RESET;
        endcase
    end

    always_comb begin
        cpu_clk_en     = 1'b0;
        periph_clk_en  = 1'b0;
        sfr_rst        = 1'b0;
        ram_wr_inhibit = 1'b0;
        freeze         = 1'b0;
        unique case (state_q)
            PM_RESET: begin
                cpu_clk_en     = tick;
                periph_clk_en  = tick;
                sfr_rst        = 1'b1;
                ram_wr_inhibit = 1'b1;
            end
            PM_RUN: begin
                cpu_clk_en    = tick;
                periph_clk_en = tick;
            end
            PM_IDLE: begin
                periph_clk_en = tick;
            end
            PM_IDLE_RSTX: begin
                cpu_clk_en     = tick;
                periph_clk_en  = tick;
                ram_wr_inhibit = 1'b1;
            end
            PM_PDOWN: begin
                freeze = 1'b1;
            end
            PM_PD_RESTART: begin
                freeze = 1'b0;
            end
            default: begin
                sfr_rst = 1'b1;
            end
        endcase
    end

    assign state = state_q;

    AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PM_PDOWN) |-> (!cpu_clk_en && !periph_clk_en)); // R7
    AST_PD_ONLY_RESET: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PM_PDOWN && !rst_pin) |=> (state_q == PM_PDOWN)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PM_IDLE && !rst_pin && !wake_irq && !qualified)
            |=> (state_q == PM_IDLE)); // R5
endmodule

// File: rtl/pm_rst_seq.sv
module pm_rst_seq
    import pm_seq_pkg::*;
#(
    parameter int STATES_PER_MC = 6,
    parameter int QUAL_MC       = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin,
    input  logic idle_set,
    input  logic pd_set,
    input  logic wake_irq,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic mc_tick,
    output logic sfr_rst,
    output logic port_preset,
    output logic ram_wr_inhibit
);
    localparam int QUAL_TICKS = STATES_PER_MC * QUAL_MC;

    pm_state_e state;
    logic      freeze;
    logic      tick;
    logic      qualified;
    logic      in_pdown;

    assign in_pdown = (state == PM_PDOWN);

    pm_clk_div #(.STATES_PER_MC(STATES_PER_MC)) u_div (
        .clk     (clk),
        .arst_n  (arst_n),
        .freeze  (freeze),
        .tick    (tick),
        .mc_tick (mc_tick)
    );

    pm_rst_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk       (clk),
        .arst_n    (arst_n),
        .rst_pin   (rst_pin),
        .clear     (in_pdown),
        .tick      (tick),
        .qualified (qualified)
    );

    pm_mode_fsm u_fsm (
        .clk            (clk),
        .arst_n         (arst_n),
        .rst_pin        (rst_pin),
        .qualified      (qualified),
        .idle_set       (idle_set),
        .pd_set         (pd_set),
        .wake_irq       (wake_irq),
        .tick           (tick),
        .state          (state),
        .freeze         (freeze),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .sfr_rst        (sfr_rst),
        .ram_wr_inhibit (ram_wr_inhibit)
    );

    assign port_preset = rst_pin | sfr_rst;

    AST_RST_NEEDS_PIN: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sfr_rst) |-> rst_pin); // R3
    AST_MC_NOT_IN_PD: assert property (@(posedge clk) disable iff (!arst_n)
        in_pdown |-> !mc_tick); // R7
endmodule

// File: tb/pm_rst_seq_tb.sv
module pm_rst_seq_tb;
    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_pin = 1'b0, idle_set = 1'b0, pd_set = 1'b0, wake_irq = 1'b0;
    logic cpu_clk_en, periph_clk_en, mc_tick, sfr_rst, port_preset, ram_wr_inhibit;

    int checks = 0, errors = 0, cycles = 0;

    // reference model state: 0 reset,1 run,2 idle,3 idle-reset-exit,4 pdown,5 pd-restart
    int m_mode = 0, m_half = 0, m_phase = 0, m_cnt = 0;

    // window counters
    int w_cpu = 0, w_per = 0, w_mc = 0, w_sfr = 0, w_lockrun = 0, w_preset_miss = 0, w_ram = 0;

    always #4 clk = ~clk;

    pm_rst_seq u_dut (
        .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .idle_set(idle_set),
        .pd_set(pd_set), .wake_irq(wake_irq), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .mc_tick(mc_tick), .sfr_rst(sfr_rst),
        .port_preset(port_preset), .ram_wr_inhibit(ram_wr_inhibit)
    );

    function automatic int m_tick();
        return (m_half == 1 && m_mode != 4) ? 1 : 0;
    endfunction

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            m_mode = 0; m_half = 0; m_phase = 0; m_cnt = 0;
        end else begin
            int t, q, nm;
            t = m_tick();
            q = (m_cnt == 12) ? 1 : 0;
            nm = m_mode;
            case (m_mode)
                0: if (!rst_pin) nm = 1;
                1: if (q) nm = 0; else if (pd_set) nm = 4; else if (idle_set) nm = 2;
                2: if (q) nm = 0; else if (rst_pin) nm = 3; else if (wake_irq) nm = 1;
                3: if (q) nm = 0; else if (!rst_pin) nm = 1;
                4: if (rst_pin) nm = 5;
                5: if (q) nm = 0; else if (!rst_pin) nm = 4;
                default: nm = 0;
            endcase
            if (!rst_pin || m_mode == 4) m_cnt = 0;
            else if (t == 1 && m_cnt < 12) m_cnt = m_cnt + 1;
            if (t == 1) m_phase = (m_phase == 5) ? 0 : m_phase + 1;
            m_half = (m_mode == 4) ? 0 : 1 - m_half;
            m_mode = nm;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #3;
        if (arst_n) begin
            int t, e_cpu, e_per, e_mc, e_sfr, e_ram, e_pre;
            t = m_tick();
            e_cpu = (t == 1 && (m_mode == 0 || m_mode == 1 || m_mode == 3)) ? 1 : 0;
            e_per = (t == 1 && m_mode <= 3) ? 1 : 0;
            e_mc  = (t == 1 && m_phase == 5) ? 1 : 0;
            e_sfr = (m_mode == 0) ? 1 : 0;
            e_ram = (m_mode == 0 || m_mode == 3) ? 1 : 0;
            e_pre = (rst_pin || m_mode == 0) ? 1 : 0;
            chk("R5", "cpu_clk_en", int'(cpu_clk_en), e_cpu);
            chk("R1", "periph_clk_en", int'(periph_clk_en), e_per);
            chk("R2", "mc_tick", int'(mc_tick), e_mc);
            chk("R3", "sfr_rst", int'(sfr_rst), e_sfr);
            chk("R6", "ram_wr_inhibit", int'(ram_wr_inhibit), e_ram);
            chk("R4", "port_preset", int'(port_preset), e_pre);
            w_cpu += int'(cpu_clk_en);
            w_per += int'(periph_clk_en);
            w_mc  += int'(mc_tick);
            w_sfr += int'(sfr_rst);
            w_ram += int'(ram_wr_inhibit);
            if (cpu_clk_en && ram_wr_inhibit && !sfr_rst) w_lockrun++;
            if (rst_pin && !port_preset) w_preset_miss++;
        end
    end

    task automatic clr_win();
        w_cpu = 0; w_per = 0; w_mc = 0; w_sfr = 0; w_lockrun = 0; w_preset_miss = 0; w_ram = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic idl, input logic pd);
        @(negedge clk);
        idle_set = idl; pd_set = pd;
        @(negedge clk);
        idle_set = 1'b0; pd_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        cyc(3);
        #3;
        chk("R11", "sfr_rst during power-on reset", int'(sfr_rst), 1);
        @(negedge clk);
        arst_n = 1'b1;
        cyc(3);
        #3;
        chk("R11", "sfr_rst released with pin low", int'(sfr_rst), 0);
        chk("R11", "ram_wr_inhibit after reset", int'(ram_wr_inhibit), 0);

        // R1 and R2: strobe rates in normal running
        @(negedge clk); clr_win();
        cyc(48);
        chk("R1", "peripheral strobes in 48 cycles", w_per, 24);
        chk("R2", "machine ticks in 48 cycles", w_mc, 4);

        // R3 and R4: a short pulse is not qualified, preset follows the pin
        clr_win();
        rst_pin = 1'b1; cyc(20); rst_pin = 1'b0; cyc(4);
        chk("R3", "short pulse core reset cycles", w_sfr, 0);
        chk("R4", "preset missing while pin high", w_preset_miss, 0);

        // R3 and R11: a long pulse resets, then the release runs normally
        clr_win();
        rst_pin = 1'b1; cyc(23);
        chk("R3", "core reset before 12 strobes", w_sfr, 0);
        cyc(20);
        chk("R3", "core reset seen after long pulse", (w_sfr > 0) ? 1 : 0, 1);
        rst_pin = 1'b0; cyc(1); #3;
        chk("R11", "sfr_rst after pin low", int'(sfr_rst), 0);
        cyc(4);

        // R5 and R10: idle, then wake
        pulse_req(1'b1, 1'b0);
        clr_win(); cyc(30);
        chk("R5", "cpu strobes in idle", w_cpu, 0);
        chk("R5", "peripheral strobes in idle", (w_per >= 14) ? 1 : 0, 1);
        wake_irq = 1'b1; cyc(1); wake_irq = 1'b0;
        clr_win(); cyc(30);
        chk("R10", "cpu strobes after wake without new request", (w_cpu >= 14) ? 1 : 0, 1);

        // R6: reset ends idle, the CPU runs with RAM locked
        pulse_req(1'b1, 1'b0);
        cyc(10);
        clr_win();
        rst_pin = 1'b1; cyc(40);
        chk("R6", "cpu strobes with RAM locked before core reset", (w_lockrun > 0) ? 1 : 0, 1);
        chk("R6", "core reset reached from idle", (w_sfr > 0) ? 1 : 0, 1);
        rst_pin = 1'b0; cyc(4);

        // R9 and R7: both requests give power-down, wake is ignored
        pulse_req(1'b1, 1'b1);
        clr_win(); cyc(30);
        chk("R9", "peripheral strobes after both requests", w_per, 0);
        wake_irq = 1'b1; cyc(2); wake_irq = 1'b0;
        clr_win(); cyc(30);
        chk("R7", "cpu strobes after wake in power-down", w_cpu, 0);
        chk("R7", "machine ticks in power-down", w_mc, 0);

        // R8: qualification restarts, short pulses fall back to power-down
        clr_win();
        rst_pin = 1'b1; cyc(20); rst_pin = 1'b0; cyc(4);
        rst_pin = 1'b1; cyc(20); rst_pin = 1'b0; cyc(10);
        chk("R8", "core reset from two short pulses", w_sfr, 0);
        chk("R8", "cpu strobes after short pulses", w_cpu, 0);
        rst_pin = 1'b1; cyc(40);
        chk("R8", "core reset after long pulse", (w_sfr > 0) ? 1 : 0, 1);
        rst_pin = 1'b0; cyc(2);
        clr_win(); cyc(20);
        chk("R11", "cpu strobes after power-down reset", (w_cpu >= 9) ? 1 : 0, 1);
        chk("R11", "RAM inhibit after release", w_ram, 0);

        finish_run();
    end
endmodule